// File: doc/BRIEF.md
# Even-Ratio Auxiliary Clock Divider

This block derives two auxiliary clocks from one reference clock. The first is a clock for an external controller, set by a 5-bit code. The second is a switching clock for a DC-DC converter, set by a 7-bit code. A non-zero code `c` gives an output period of `2*c` reference cycles. A counter measures `c` reference cycles and a toggle stage follows it. The toggle stage is what makes the factor even, and it also gives an exact 50% duty cycle.

A code of zero does not mean a ratio. It means the output is off. Each output is also gated by its own enable and by an active-low standby input. In standby both dividers are held in their start state. A registered flag reports when the converter is enabled with an all-zero converter code, which leaves the oscillator-dependent core without a switching clock.

A new code takes effect only at the next output toggle, so a half period never ends early. An output that is off stays low. When it is enabled again it rises on the first qualifying edge and then runs full periods. Reset is asserted asynchronously and released through a two-stage synchronizer. All outputs are registered.

Top module: `cdiv_aux_clocks`

## Requirements
- R1: During reset, and for the two reference edges after `rst_n` rises, `ctl_clk`, `sw_clk` and `core_off` are 0.
- R2: With the controller clock running and code `ctl_div` = k (1 to 31) held, `ctl_clk` is high for k cycles and low for k cycles, a period of 2k.
- R3: With the converter clock running and code `sw_div` = l (1 to 127) held, `sw_clk` is high for l cycles and low for l cycles, a period of 2l.
- R4: When `ctl_div` is 0 at a reference edge, `ctl_clk` is 0 after that edge, whatever `ctl_en` is.
- R5: When `ctl_en` is 0 or `stby_n` is 0 at a reference edge, `ctl_clk` is 0 after that edge.
- R6: When `sw_en` is 0, `sw_div` is 0, or `stby_n` is 0 at a reference edge, `sw_clk` is 0 after that edge.
- R7: `core_off` equals (`sw_en` = 1 and `sw_div` = 0) as sampled at the previous reference edge, and it does not depend on `stby_n`.
- R8: A code changed while its output runs is first used for the half period that begins at the next toggle. The half period in progress keeps its old length.
- R9: When an output's run condition is true at an edge after being false at the previous edge, the output is 1 after that edge and stays high for a full half period.
- R10: Leaving standby restarts both dividers from their start state, so each running output rises on the first edge at which `stby_n` is sampled high (as in R9).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| stby_n | input | 1 | Standby, active low; stops and clears both dividers |
| ctl_en | input | 1 | Controller clock buffer enable |
| ctl_div | input | 5 | Controller clock code; 0 = off, k gives divide by 2k |
| sw_en | input | 1 | Converter clock enable |
| sw_div | input | 7 | Converter clock code; 0 = off, l gives divide by 2l |
| ctl_clk | output | 1 | Divided clock for the external controller |
| sw_clk | output | 1 | Divided switching clock for the converter |
| core_off | output | 1 | Converter enabled with an all-zero code; core must stop |

## Verification
A wrong count or a wrong latched code in a divider shows up at the output as a high or low phase of the wrong length. It becomes visible at the first toggle after the fault, which is at most one half period later, so at most 127 reference cycles. A divider that is not cleared when it stops shows up as a late first rise, or as a short first high phase, on the first edge after re-enable. A wrong gating term shows up as a clock that keeps running, or stays silent, one edge after the enable changes. A cycle-exact bench model covers all of these, while random enable, standby and code changes arrive in the middle of phases.

// File: rtl/cdiv_pkg.sv
`timescale 1ns/1ps
package cdiv_pkg;

  // Default code widths of the two dividers
  localparam int unsigned CTL_W = 5;
  localparam int unsigned SW_W  = 7;

  // Decoded run conditions of the two outputs plus the core shutdown flag
  typedef struct packed {
    logic ctl_run;
    logic sw_run;
    logic core_off;
  } cdiv_gate_t;

endpackage

// File: rtl/cdiv_rst_sync.sv
`timescale 1ns/1ps
module cdiv_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/cdiv_gate.sv
`timescale 1ns/1ps
module cdiv_gate
  import cdiv_pkg::*;
#(
  parameter int unsigned CW = CTL_W,
  parameter int unsigned SW = SW_W
) (
  input  logic          stby_n,
  input  logic          ctl_en,
  input  logic [CW-1:0] ctl_div,
  input  logic          sw_en,
  input  logic [SW-1:0] sw_div,
  output cdiv_gate_t    gate
);

  logic ctl_code_nz;
  logic sw_code_nz;

  always_comb begin
    ctl_code_nz   = |ctl_div;
    sw_code_nz    = |sw_div;
    // A zero code disables the controller clock regardless of its enable bit
    gate.ctl_run  = stby_n & ctl_en & ctl_code_nz;
    gate.sw_run   = stby_n & sw_en & sw_code_nz;
    // The converter needs at least one code bit set for the core to run
    gate.core_off = sw_en & ~sw_code_nz;
  end

endmodule

// File: rtl/cdiv_even_div.sv
`timescale 1ns/1ps
module cdiv_even_div #(
  parameter int unsigned W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic [W-1:0] code,
  output logic         clk_out
);

  localparam logic [W-1:0] ONE = W'(1);

  logic [W-1:0] cnt_q, cnt_d;
  logic [W-1:0] half_q, half_d;
  logic         out_q, out_d;
  logic         at_end;

  always_comb begin
    cnt_d  = cnt_q;
    half_d = half_q;
    out_d  = out_q;
    at_end = (cnt_q == half_q);
    if (!run) begin
      // Stopped: hold low and park the counter at its terminal value,
      // so the first running edge produces a rising edge.
      out_d  = 1'b0;
      half_d = code;
      cnt_d  = code;
    end else if (at_end) begin
      // Toggle stage; the code is sampled here only
      out_d  = ~out_q;
      half_d = code;
      cnt_d  = ONE;
    end else begin
      cnt_d  = cnt_q + ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      half_q <= '0;
      out_q  <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      half_q <= half_d;
      out_q  <= out_d;
    end
  end

  assign clk_out = out_q;

endmodule

// File: rtl/cdiv_aux_clocks.sv
`timescale 1ns/1ps
module cdiv_aux_clocks
  import cdiv_pkg::*;
#(
  parameter int unsigned CW = CTL_W,
  parameter int unsigned SW = SW_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          stby_n,
  input  logic          ctl_en,
  input  logic [CW-1:0] ctl_div,
  input  logic          sw_en,
  input  logic [SW-1:0] sw_div,
  output logic          ctl_clk,
  output logic          sw_clk,
  output logic          core_off
);

  logic       rst_core_n;
  cdiv_gate_t gate;
  logic       core_off_q, core_off_d;

  cdiv_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_core_n)
  );

  cdiv_gate #(.CW(CW), .SW(SW)) u_gate (
    .stby_n  (stby_n),
    .ctl_en  (ctl_en),
    .ctl_div (ctl_div),
    .sw_en   (sw_en),
    .sw_div  (sw_div),
    .gate    (gate)
  );

  cdiv_even_div #(.W(CW)) u_ctl_div (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .run     (gate.ctl_run),
    .code    (ctl_div),
    .clk_out (ctl_clk)
  );

  cdiv_even_div #(.W(SW)) u_sw_div (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .run     (gate.sw_run),
    .code    (sw_div),
    .clk_out (sw_clk)
  );

  always_comb begin
    core_off_d = gate.core_off;
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      core_off_q <= 1'b0;
    end else begin
      core_off_q <= core_off_d;
    end
  end

  assign core_off = core_off_q;

endmodule

// File: rtl/cdiv_aux_clocks_chk.sv
`timescale 1ns/1ps
module cdiv_aux_clocks_chk #(
  parameter int unsigned CW = 5,
  parameter int unsigned SW = 7
) (
  input logic          clk,
  input logic          rst_n,
  input logic          stby_n,
  input logic          ctl_en,
  input logic [CW-1:0] ctl_div,
  input logic          sw_en,
  input logic [SW-1:0] sw_div,
  input logic          ctl_clk,
  input logic          sw_clk,
  input logic          core_off
);

  logic ctl_go;
  logic ctl_go_prev;

  assign ctl_go = stby_n && ctl_en && (ctl_div != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctl_go_prev <= 1'b0;
    else        ctl_go_prev <= ctl_go;
  end

  // R4
  p_ctl_low_zero_code_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_div == '0) |=> !ctl_clk);

  // R5
  p_ctl_low_disabled_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_en || !stby_n) |=> !ctl_clk);

  // R6
  p_sw_low_disabled_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!sw_en || !stby_n || (sw_div == '0)) |=> !sw_clk);

  // R7
  p_core_off_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_en && (sw_div == '0)) |=> core_off);

  // R7
  p_core_off_clr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(sw_en && (sw_div == '0)) |=> !core_off);

  // R9
  p_ctl_first_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_go && !ctl_go_prev) |=> ctl_clk);

endmodule

bind cdiv_aux_clocks cdiv_aux_clocks_chk #(.CW(CW), .SW(SW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_core_n),
  .stby_n   (stby_n),
  .ctl_en   (ctl_en),
  .ctl_div  (ctl_div),
  .sw_en    (sw_en),
  .sw_div   (sw_div),
  .ctl_clk  (ctl_clk),
  .sw_clk   (sw_clk),
  .core_off (core_off)
);

// File: tb/cdiv_aux_clocks_tb_top.sv
`timescale 1ns/1ps
module cdiv_aux_clocks_tb_top;

  logic       clk;
  logic       rst_n;
  logic       stby_n;
  logic       ctl_en;
  logic [4:0] ctl_div;
  logic       sw_en;
  logic [6:0] sw_div;
  logic       ctl_clk;
  logic       sw_clk;
  logic       core_off;

  int checks;
  int errors;

  cdiv_aux_clocks dut_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .stby_n   (stby_n),
    .ctl_en   (ctl_en),
    .ctl_div  (ctl_div),
    .sw_en    (sw_en),
    .sw_div   (sw_div),
    .ctl_clk  (ctl_clk),
    .sw_clk   (sw_clk),
    .core_off (core_off)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // Reference model, built from the requirements
  bit    r1q, r2q;
  bit    e_ctl, e_sw, e_off;
  int    c_left, s_left, c_len, s_len;
  bit    c_prev_run, s_prev_run, prev_stby;
  string c_tag, s_tag, o_tag;

  always @(posedge clk or negedge rst_n) begin
    bit c_run, s_run;
    if (!rst_n) begin
      r1q = 0; r2q = 0;
      e_ctl = 0; e_sw = 0; e_off = 0;
      c_left = 1; s_left = 1; c_len = 0; s_len = 0;
      c_prev_run = 0; s_prev_run = 0; prev_stby = 1;
      c_tag = "R1"; s_tag = "R1"; o_tag = "R1";
    end else begin
      c_run = stby_n && ctl_en && (ctl_div != 0);
      s_run = stby_n && sw_en && (sw_div != 0);
      if (!r2q) begin
        e_ctl = 0; e_sw = 0; e_off = 0; c_left = 1; s_left = 1;
        c_tag = "R1"; s_tag = "R1"; o_tag = "R1";
        c_run = 0; s_run = 0;
      end else begin
        // controller clock
        if (ctl_div == 0)              c_tag = "R4";
        else if (!ctl_en || !stby_n)   c_tag = "R5";
        else if (!prev_stby)           c_tag = "R10";
        else if (!c_prev_run)          c_tag = "R9";
        else if (int'(ctl_div) != c_len) c_tag = "R8";
        else                           c_tag = "R2";
        if (!c_run) begin e_ctl = 0; c_left = 1; end
        else if (c_left == 1) begin e_ctl = !e_ctl; c_left = ctl_div; c_len = ctl_div; end
        else c_left--;
        // converter clock
        if (!s_run)                    s_tag = "R6";
        else if (!prev_stby)           s_tag = "R10";
        else if (!s_prev_run)          s_tag = "R9";
        else if (int'(sw_div) != s_len) s_tag = "R8";
        else                           s_tag = "R3";
        if (!s_run) begin e_sw = 0; s_left = 1; end
        else if (s_left == 1) begin e_sw = !e_sw; s_left = sw_div; s_len = sw_div; end
        else s_left--;
        e_off = sw_en && (sw_div == 0);
        o_tag = "R7";
      end
      c_prev_run = c_run; s_prev_run = s_run; prev_stby = stby_n;
      r2q = r1q; r1q = 1;
    end
  end

  task automatic check_bit(input string tag, input string what, input logic act, input bit exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s at %0t: actual %b expected %b", tag, what, $time, act, exp);
    end
  endtask

  // Compare every cycle, away from the active edge
  bit cmp_on;
  always @(negedge clk) begin
    if (cmp_on) begin
      check_bit(c_tag, "ctl_clk", ctl_clk, e_ctl);
      check_bit(s_tag, "sw_clk", sw_clk, e_sw);
      check_bit(o_tag, "core_off", core_off, e_off);
    end
  end

  task automatic drive(input bit st, input bit ce, input int cd, input bit se, input int sd, input int n);
    @(negedge clk);
    stby_n = st; ctl_en = ce; ctl_div = 5'(cd); sw_en = se; sw_div = 7'(sd);
    repeat (n - 1) @(negedge clk);
  endtask

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_c10c));
    checks = 0; errors = 0; cmp_on = 0;
    rst_n = 0; stby_n = 1; ctl_en = 1; ctl_div = 5'd3; sw_en = 1; sw_div = 7'd0;
    repeat (3) @(negedge clk);
    // R1: reset state at the ports even with active-looking inputs
    check_bit("R1", "ctl_clk", ctl_clk, 0);
    check_bit("R1", "sw_clk", sw_clk, 0);
    check_bit("R1", "core_off", core_off, 0);
    cmp_on = 1;
    rst_n = 1;
    drive(1, 1, 1, 1, 1, 20);      // R2/R3 divide by 2
    drive(1, 1, 31, 1, 127, 600);  // R2/R3 largest ratios
    drive(1, 1, 0, 1, 5, 40);      // R4
    drive(1, 0, 7, 1, 5, 40);      // R5 buffer off
    drive(0, 1, 7, 1, 5, 40);      // R5/R6 standby
    drive(1, 1, 7, 1, 5, 60);      // R10 leave standby
    drive(1, 1, 7, 1, 0, 20);      // R7 core off
    drive(1, 1, 7, 0, 0, 20);      // R7 cleared when converter disabled
    drive(1, 1, 4, 1, 9, 6);       // R8 mid-phase change follows
    drive(1, 1, 2, 1, 3, 60);
    for (int seg = 0; seg < 200; seg++) begin
      bit st, ce, se; int cd, sd;
      st = ($urandom % 10) != 0;
      ce = ($urandom % 8) != 0;
      se = ($urandom % 6) != 0;
      cd = (($urandom % 10) == 0) ? 0 : 1 + ($urandom % 31);
      sd = (($urandom % 10) == 0) ? 0 : 1 + ($urandom % 127);
      drive(st, ce, cd, se, sd, 3 + ($urandom % 150));
    end
    @(negedge clk);
    cmp_on = 0;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule